// File: doc/BRIEF.md
# In-band pause/resume transmit gate

This block sits between a local byte sender and a serial transmitter. It watches the bytes arriving from the far end, and two reserved byte values in that stream stop and restart the outgoing traffic. The pause code is 0x13 and the resume code is 0x11. Outgoing bytes travel on a valid/ready stream. While the link runs, the gate is transparent in the same cycle. While the link is paused, the gate offers no new byte to the transmitter.

Received bytes that are not control codes go on to a local consumer one cycle later. The two control codes are consumed by the gate and are never forwarded. A registered status output shows whether the link is paused. A byte that was already offered to the transmitter before a pause takes effect stays offered until the transmitter accepts it. The pause therefore only acts at a byte boundary, and a valid/ready transfer is never broken.

Top module: `swfc_gate`

## Requirements
- R1: After a synchronous reset, `paused` is 0 and `fwd_valid` is 0, and the gate is in the running state.
- R2: A received byte equal to 0x13 (with `rx_valid` high) sets `paused` to 1 on the next cycle. From then on no new byte is offered: `tx_out_valid` and `tx_in_ready` stay 0.
- R3: A received byte equal to 0x11 while paused clears `paused` on the next cycle. Traffic then flows again.
- R4: A byte offered to the transmitter (`tx_out_valid` high, `tx_out_ready` low) stays offered in the following cycles, even if a pause has taken effect, until it is accepted.
- R5: A received 0x11 or 0x13 is not forwarded. Any other received byte appears on `fwd_data` with `fwd_valid` high exactly one cycle after it arrives, with its value unchanged.
- R6: A 0x13 received while paused, or a 0x11 received while running, leaves `paused` unchanged. With no control code received, `paused` also holds its value.
- R7: While running, `tx_out_valid` equals `tx_in_valid`, `tx_out_data` equals `tx_in_data`, and `tx_in_ready` equals `tx_out_ready`, all in the same cycle.
- R8: If a 0x13 arrives in the same cycle as a completed transmit handshake, that byte is transferred. Only later bytes are held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe for a received byte |
| rx_data | input | DATA_W | Received byte |
| tx_in_valid | input | 1 | Local sender has a byte |
| tx_in_data | input | DATA_W | Byte from local sender |
| tx_in_ready | output | 1 | Gate accepts the sender's byte |
| tx_out_valid | output | 1 | Byte offered to the transmitter |
| tx_out_data | output | DATA_W | Byte to the transmitter |
| tx_out_ready | input | 1 | Transmitter takes the byte |
| fwd_valid | output | 1 | Forwarded received byte valid |
| fwd_data | output | DATA_W | Forwarded received byte |
| paused | output | 1 | Link currently paused |

## Verification
Two things can happen in the same clock: a pause code arrives on the receive side, and a transmit byte is either mid-handshake or still waiting to be accepted. The bench provokes this in two ways. It randomly stalls `tx_out_ready` while control codes are injected at a high rate. It also runs directed cases where the pause lands exactly on an accepting cycle and on a stalled offer. It judges the result by checking that the in-flight byte still completes, and that the next byte is withheld starting on the cycle after the pause.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic [1:0] {
    CLS_DATA   = 2'd0,
    CLS_PAUSE  = 2'd1,
    CLS_RESUME = 2'd2
  } rx_class_e;
endpackage

// File: rtl/swfc_rx_classify.sv
module swfc_rx_classify
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PAUSE_CODE  = 8'h13,
  parameter logic [DATA_W-1:0] RESUME_CODE = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output rx_class_e         rx_class,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);
  always_comb begin
    if (rx_data == PAUSE_CODE)       rx_class = CLS_PAUSE;
    else if (rx_data == RESUME_CODE) rx_class = CLS_RESUME;
    else                             rx_class = CLS_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= rx_valid && (rx_class == CLS_DATA);
      if (rx_valid) fwd_data <= rx_data;
    end
  end

  assert_ctrl_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && (rx_data == PAUSE_CODE || rx_data == RESUME_CODE) |=> !fwd_valid);
  assert_data_passed_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_data != PAUSE_CODE && rx_data != RESUME_CODE
      |=> fwd_valid && fwd_data == $past(rx_data));
endmodule

// File: rtl/swfc_pause_ctl.sv
module swfc_pause_ctl
  import swfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_valid,
  input  rx_class_e ev_class,
  output logic      paused
);
  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
    end else if (ev_valid) begin
      case (ev_class)
        CLS_PAUSE:  paused <= 1'b1;
        CLS_RESUME: paused <= 1'b0;
        default:    paused <= paused;
      endcase
    end
  end

  assert_reset_running_R1: assert property (@(posedge clk) rst |=> !paused);
  assert_pause_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_class == CLS_PAUSE |=> paused);
  assert_resume_clears_R3: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_class == CLS_RESUME |=> !paused);
  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_class != CLS_DATA) |=> $stable(paused));
endmodule

// File: rtl/swfc_tx_gate.sv
module swfc_tx_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paused,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic committed;
  logic allow;

  assign allow     = !paused || committed;
  assign out_valid = in_valid && allow;
  assign in_ready  = out_ready && allow;
  assign out_data  = in_data;

  always_ff @(posedge clk) begin
    if (rst) committed <= 1'b0;
    else     committed <= out_valid && !out_ready;
  end

  assert_offer_kept_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> (!in_valid || out_valid));
  assert_no_new_offer_R2: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && !out_ready) |=> (!paused || (!out_valid && !in_ready)));
  assert_transparent_R7: assert property (@(posedge clk) disable iff (rst)
    !paused |-> (out_valid == in_valid && in_ready == out_ready));
endmodule

// File: rtl/swfc_gate.sv
module swfc_gate
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PAUSE_CODE  = 8'h13,
  parameter logic [DATA_W-1:0] RESUME_CODE = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_in_valid,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic              paused
);
  rx_class_e rx_class;

  swfc_rx_classify #(
    .DATA_W(DATA_W), .PAUSE_CODE(PAUSE_CODE), .RESUME_CODE(RESUME_CODE)
  ) u_classify (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_class(rx_class), .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  swfc_pause_ctl u_pause (
    .clk(clk), .rst(rst), .ev_valid(rx_valid), .ev_class(rx_class),
    .paused(paused)
  );

  swfc_tx_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .paused(paused),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready)
  );
endmodule

// File: tb/swfc_gate_test.sv
`timescale 1ns/1ps
module swfc_gate_test;
  localparam logic [7:0] XOFF = 8'h13;
  localparam logic [7:0] XON  = 8'h11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_in_valid = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic tx_in_ready, tx_out_valid, fwd_valid, paused;
  logic [7:0] tx_out_data, fwd_data;
  logic tx_out_ready = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  bit m_paused = 1'b0, m_commit = 1'b0, m_fwd_v = 1'b0;
  logic [7:0] m_fwd_d = '0;
  string m_ptag = "R1";
  bit src_v = 1'b0;
  logic [7:0] src_d = '0;
  bit last_hs = 1'b0;

  always #2.5 clk = ~clk;

  swfc_gate uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .paused(paused)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_ctrl(input logic [7:0] d);
    return d == XOFF || d == XON;
  endfunction

  // one clock: drive at negedge, check before posedge, update model after it
  task automatic step(input bit rv, input logic [7:0] rd, input bit sv,
                      input logic [7:0] sd, input bit rdy);
    bit run, ev, eir;
    string ttag;
    @(negedge clk);
    rx_valid = rv; rx_data = rd; tx_in_valid = sv; tx_in_data = sd; tx_out_ready = rdy;
    #1;
    run = !m_paused || m_commit;
    ev  = sv && run;
    eir = rdy && run;
    ttag = m_commit ? "R4" : (m_paused ? "R2" : "R7");
    check(ttag, tx_out_valid, ev, "tx_out_valid");
    check(ttag, tx_in_ready, eir, "tx_in_ready");
    if (ev) check("R7", tx_out_data, sd, "tx_out_data");
    check(m_ptag, paused, m_paused, "paused");
    check("R5", fwd_valid, m_fwd_v, "fwd_valid");
    if (m_fwd_v) check("R5", fwd_data, m_fwd_d, "fwd_data");
    @(posedge clk);
    last_hs  = sv && eir;
    m_commit = ev && !rdy;
    m_fwd_v  = rv && !is_ctrl(rd);
    if (rv) m_fwd_d = rd;
    if (rv && rd == XOFF) begin m_ptag = m_paused ? "R6" : "R2"; m_paused = 1'b1; end
    else if (rv && rd == XON) begin m_ptag = m_paused ? "R3" : "R6"; m_paused = 1'b0; end
    else m_ptag = "R6";
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1", paused, 0, "paused after reset");
    check("R1", fwd_valid, 0, "fwd_valid after reset");

    // R7: transparent while running
    step(0, 8'h00, 1, 8'hA5, 1);
    step(1, 8'h41, 1, 8'h5A, 0);
    step(0, 8'h00, 1, 8'h5A, 1);   // R5: 0x41 forwarded now

    // R8: pause arrives on an accepting cycle; that byte goes, next is held
    step(1, XOFF, 1, 8'h77, 1);
    @(negedge clk); #1;
    check("R2", paused, 1, "paused after XOFF");
    step(0, 8'h00, 1, 8'h78, 1);
    check("R8", int'(last_hs), 0, "no transfer after pause");
    // R6: second XOFF keeps pause, XON releases
    step(1, XOFF, 1, 8'h78, 1);
    step(1, XON, 1, 8'h78, 1);
    step(0, 8'h00, 1, 8'h78, 1);
    check("R3", int'(last_hs), 1, "transfer after resume");
    // R6: XON while running
    step(1, XON, 0, 8'h00, 0);

    // R4: stalled offer, then pause; offer persists until accepted
    step(0, 8'h00, 1, 8'h3C, 0);
    step(1, XOFF, 1, 8'h3C, 0);
    step(0, 8'h00, 1, 8'h3C, 0);
    check("R4", tx_out_valid, 1, "offer held while paused");
    step(0, 8'h00, 1, 8'h3C, 1);
    check("R4", int'(last_hs), 1, "held byte accepted");
    step(0, 8'h00, 1, 8'h3D, 1);
    check("R2", int'(last_hs), 0, "next byte withheld");
    step(1, XON, 0, 8'h00, 0);

    // random phase
    src_v = 1'b0; last_hs = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit rv; logic [7:0] rd; int pick;
      if (!src_v || last_hs) begin
        src_v = ($urandom % 4) != 0;
        src_d = 8'($urandom);
      end
      rv = ($urandom % 3) == 0;
      pick = $urandom % 10;
      rd = (pick < 2) ? XOFF : (pick < 4) ? XON : 8'($urandom);
      step(rv, rd, src_v, src_d, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule